// File: doc/BRIEF.md
# Multiplexed Grid Scanner with PWM Dimming

This block generates the scan timing for a three-phase multiplexed fluorescent display. A free-running prescaler divides the system oscillator clock into a bit-time tick. Counted in bit times, a display cycle is made of three grid slots of 1024 bit times each. In every slot the block enables one grid pattern and gates 37 segment enables from the matching bank of a 111-bit display latch. A 10-bit brightness value sets how long the segments stay lit inside each slot. The value is clamped so that at least 8 bit times of every slot stay dark.

A select input picks between two grid sequences. With the select low, the three grids are scanned one after another. With the select high, the third slot drives grids 1 and 2 together, and grid 3 stays idle. This second sequence suits panels whose patterns run continuously across grid boundaries. The brightness value is adopted only at slot boundaries and the select only at display-cycle boundaries, so neither one can cut a pulse short or restart the scan in the middle of a cycle. The display latch itself is used live: a latch change shows up on the segment outputs at once.

Top module: `vfd_grid_scanner`

## Requirements
- R1: While reset is asserted and immediately after it, all grid and segment enables are 0. The scan restarts at slot 1, bit time 0, with an adopted brightness of 0 and the grid1+grid2 sequence selected.
- R2: One bit time is 4 clock cycles. The grid enables change only on a bit-time boundary, so the first grid enable rises exactly 20 clocks after reset is released.
- R3: Each slot lasts 1024 bit times, and three slots form one cycle of 3072 bit times. With the adopted select at 0, the slots drive grid_en = 3'b001, 3'b010 and 3'b100 in that order (bit 0 is grid 1, bit 1 is grid 2, bit 2 is grid 3).
- R4: With the adopted select at 1, the third slot drives grid_en = 3'b011 and grid_en[2] is never set. No other grid_en value than 000, 001, 010, 100 and 011 ever appears.
- R5: Within a slot, the grid enable is 0 for bit times 0 to 4 and 1 for bit times 5 to 1023, which is 1019 bit times.
- R6: In slot k (k = 0, 1, 2), seg_en[n] equals disp_latch[37*k + n] whenever the segment window is open, and is 0 otherwise. No segment is ever enabled while all grids are off.
- R7: The segment window opens at bit time 8 of the slot and stays open for min(B, 1016) bit times, where B is the adopted brightness. Brightness values of 1017 to 1023 give the same 1016 bit times.
- R8: An adopted brightness of 0 keeps every segment enable at 0 for the whole slot.
- R9: The brightness input is adopted only at the start of a slot. A change in the middle of a slot has no effect until the next slot begins.
- R10: The select input is adopted only at the start of a display cycle. A change in the middle of a cycle does not alter the grid pattern of the remaining slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| disp_latch | input | 111 | Display latch, three banks of 37 segment bits |
| bright | input | 10 | Brightness value in bit times |
| seq_sel | input | 1 | 0: three separate grids; 1: grid1, grid2, grid1+grid2 |
| grid_en | output | 3 | Grid enables, bit 0 = grid 1 |
| seg_en | output | 37 | Segment enables |

## Verification
The hardest cases to reach are inputs that change in the middle of a slot or a cycle, because the effect of those changes is deferred. The outputs look correct unless the bench knows exactly which slot boundary the new value should take effect at. The bench changes brightness at a known bit time inside slot 1 and then checks that the segments stay lit for the rest of that slot and go dark in the next one. It also changes the select inside the second slot and checks that the third slot still drives grids 1 and 2 together, and that the new order appears only in the next cycle. Random changes to brightness (including 0 and clamped values), the latch and the select at arbitrary clocks are then compared every clock against a cycle-accurate bench model.

// File: rtl/vfd_scan_pkg.sv
package vfd_scan_pkg;

    localparam int NUM_GRIDS = 3;
    localparam int NUM_SLOTS = 3;

    typedef enum logic [1:0] {
        SLOT_A = 2'd0,
        SLOT_B = 2'd1,
        SLOT_C = 2'd2
    } slot_e;

    localparam logic [NUM_GRIDS-1:0] GRID_PAT_A    = 3'b001;
    localparam logic [NUM_GRIDS-1:0] GRID_PAT_B    = 3'b010;
    localparam logic [NUM_GRIDS-1:0] GRID_PAT_C    = 3'b100;
    localparam logic [NUM_GRIDS-1:0] GRID_PAT_PAIR = 3'b011;

endpackage

// File: rtl/vfd_bit_tick.sv
module vfd_bit_tick #(
    parameter int OSC_PER_BIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PRE_W = (OSC_PER_BIT > 1) ? $clog2(OSC_PER_BIT) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(OSC_PER_BIT - 1);

    logic [PRE_W-1:0] pre_d, pre_q;

    always_comb begin
        tick  = (pre_q == PRE_LAST);
        pre_d = tick ? '0 : pre_q + PRE_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/vfd_slot_seq.sv
module vfd_slot_seq
    import vfd_scan_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] bright_in,
    input  logic             sel_in,
    output logic [CNT_W-1:0] bit_cnt,
    output slot_e            slot,
    output logic [CNT_W-1:0] bright_act,
    output logic             sel_act
);
    localparam logic [CNT_W-1:0] BIT_LAST = '1;

    typedef struct packed {
        logic [CNT_W-1:0] bit_cnt;
        slot_e            slot;
        logic [CNT_W-1:0] bright;
        logic             sel;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick) begin
            if (st_q.bit_cnt == BIT_LAST) begin
                st_d.bit_cnt = '0;
                st_d.bright  = bright_in;
                case (st_q.slot)
                    SLOT_A:  st_d.slot = SLOT_B;
                    SLOT_B:  st_d.slot = SLOT_C;
                    default: begin
                        st_d.slot = SLOT_A;
                        st_d.sel  = sel_in;
                    end
                endcase
            end else begin
                st_d.bit_cnt = st_q.bit_cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.bit_cnt <= '0;
            st_q.slot    <= SLOT_A;
            st_q.bright  <= '0;
            st_q.sel     <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign bit_cnt    = st_q.bit_cnt;
    assign slot       = st_q.slot;
    assign bright_act = st_q.bright;
    assign sel_act    = st_q.sel;
endmodule

// File: rtl/vfd_out_drive.sv
module vfd_out_drive
    import vfd_scan_pkg::*;
#(
    parameter int CNT_W      = 10,
    parameter int NSEG       = 37,
    parameter int GRID_LEAD  = 5,
    parameter int SEG_LEAD   = 8,
    parameter int BRIGHT_MAX = 1016
) (
    input  logic [CNT_W-1:0]          bit_cnt,
    input  slot_e                     slot,
    input  logic [CNT_W-1:0]          bright_act,
    input  logic                      sel_act,
    input  logic [NUM_SLOTS*NSEG-1:0] disp_latch,
    output logic [NUM_GRIDS-1:0]      grid_en,
    output logic [NSEG-1:0]           seg_en
);
    localparam logic [CNT_W-1:0] G_LEAD = CNT_W'(GRID_LEAD);
    localparam logic [CNT_W-1:0] S_LEAD = CNT_W'(SEG_LEAD);
    localparam logic [CNT_W-1:0] B_MAX  = CNT_W'(BRIGHT_MAX);

    logic [CNT_W-1:0]     on_len;
    logic [CNT_W-1:0]     seg_pos;
    logic                 seg_win;
    logic                 grid_win;
    logic [NUM_GRIDS-1:0] grid_pat;
    logic [NSEG-1:0]      bank;

    always_comb begin
        on_len   = (bright_act > B_MAX) ? B_MAX : bright_act;
        seg_pos  = bit_cnt - S_LEAD;
        grid_win = (bit_cnt >= G_LEAD);
        seg_win  = (bit_cnt >= S_LEAD) && (seg_pos < on_len);
        case (slot)
            SLOT_A:  begin grid_pat = GRID_PAT_A; bank = disp_latch[0 +: NSEG];      end
            SLOT_B:  begin grid_pat = GRID_PAT_B; bank = disp_latch[NSEG +: NSEG];   end
            default: begin
                grid_pat = sel_act ? GRID_PAT_PAIR : GRID_PAT_C;
                bank     = disp_latch[2*NSEG +: NSEG];
            end
        endcase
        grid_en = grid_win ? grid_pat : '0;
    end

    for (genvar n = 0; n < NSEG; n++) begin : g_seg
        assign seg_en[n] = seg_win & bank[n];
    end
endmodule

// File: rtl/vfd_grid_scanner.sv
module vfd_grid_scanner
    import vfd_scan_pkg::*;
#(
    parameter int OSC_PER_BIT  = 4,
    parameter int CNT_W        = 10,
    parameter int SEG_PER_GRID = 37,
    parameter int GRID_LEAD    = 5,
    parameter int SEG_LEAD     = 8,
    parameter int BRIGHT_MAX   = 1016
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NUM_SLOTS*SEG_PER_GRID-1:0]   disp_latch,
    input  logic [CNT_W-1:0]                    bright,
    input  logic                                seq_sel,
    output logic [NUM_GRIDS-1:0]                grid_en,
    output logic [SEG_PER_GRID-1:0]             seg_en
);
    logic             bit_tick;
    logic [CNT_W-1:0] bit_cnt;
    slot_e            slot;
    logic [CNT_W-1:0] bright_act;
    logic             sel_act;

    vfd_bit_tick #(
        .OSC_PER_BIT (OSC_PER_BIT)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (bit_tick)
    );

    vfd_slot_seq #(
        .CNT_W (CNT_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (bit_tick),
        .bright_in  (bright),
        .sel_in     (seq_sel),
        .bit_cnt    (bit_cnt),
        .slot       (slot),
        .bright_act (bright_act),
        .sel_act    (sel_act)
    );

    vfd_out_drive #(
        .CNT_W      (CNT_W),
        .NSEG       (SEG_PER_GRID),
        .GRID_LEAD  (GRID_LEAD),
        .SEG_LEAD   (SEG_LEAD),
        .BRIGHT_MAX (BRIGHT_MAX)
    ) u_drive (
        .bit_cnt    (bit_cnt),
        .slot       (slot),
        .bright_act (bright_act),
        .sel_act    (sel_act),
        .disp_latch (disp_latch),
        .grid_en    (grid_en),
        .seg_en     (seg_en)
    );
endmodule

// File: rtl/vfd_grid_scanner_chk.sv
module vfd_grid_scanner_chk #(
    parameter int NG = 3,
    parameter int NS = 37
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bit_tick,
    input logic [NG-1:0] grid_en,
    input logic [NS-1:0] seg_en
);
    // R1
    reset_dark_chk: assert property (@(posedge clk)
        !rst_n |=> (grid_en == '0 && seg_en == '0));

    // R2
    grid_bitsync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> $stable(grid_en));

    // R2
    tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |=> !bit_tick);

    // R4
    grid_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grid_en == 3'b000 || grid_en == 3'b001 || grid_en == 3'b010 ||
         grid_en == 3'b100 || grid_en == 3'b011));

    // R6
    seg_needs_grid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_en != '0) |-> (grid_en != '0));
endmodule

bind vfd_grid_scanner vfd_grid_scanner_chk #(
    .NG (vfd_scan_pkg::NUM_GRIDS),
    .NS (SEG_PER_GRID)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_tick (bit_tick),
    .grid_en  (grid_en),
    .seg_en   (seg_en)
);

// File: tb/vfd_grid_scanner_tb_top.sv
`timescale 1ns/1ps
module vfd_grid_scanner_tb_top;
    localparam int NSEG  = 37;
    localparam int CYC   = 12288;   // clocks per display cycle

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [110:0]     latch_r = '0;
    logic [9:0]       bright_r = '0;
    logic             sel_r = 1'b1;
    logic [2:0]       grid_en;
    logic [NSEG-1:0]  seg_en;

    int vectors = 0;
    int miscompares = 0;
    bit meas = 0;
    bit rnd = 0;
    int cnt_seg0 = 0;
    int cnt_pair = 0;
    int cnt_g3 = 0;
    int cnt_anyseg = 0;

    always #10 clk = ~clk;

    vfd_grid_scanner dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .disp_latch (latch_r),
        .bright     (bright_r),
        .seq_sel    (sel_r),
        .grid_en    (grid_en),
        .seg_en     (seg_en)
    );

    // bench model of the scan position, built from the requirements
    int m_pre, m_bit, m_slot, m_br;
    bit m_sel;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pre <= 0; m_bit <= 0; m_slot <= 0; m_br <= 0; m_sel <= 1'b1;
        end else if (m_pre == 3) begin
            m_pre <= 0;
            if (m_bit == 1023) begin
                m_bit <= 0;
                m_br  <= int'(bright_r);
                if (m_slot == 2) begin
                    m_slot <= 0;
                    m_sel  <= sel_r;
                end else m_slot <= m_slot + 1;
            end else m_bit <= m_bit + 1;
        end else m_pre <= m_pre + 1;
    end

    function automatic logic [2:0] exp_grid();
        logic [2:0] p;
        if (m_bit < 5) return 3'b000;
        case (m_slot)
            0: p = 3'b001;
            1: p = 3'b010;
            default: p = m_sel ? 3'b011 : 3'b100;
        endcase
        return p;
    endfunction

    function automatic logic [NSEG-1:0] exp_seg();
        logic [NSEG-1:0] s = '0;
        int len = (m_br > 1016) ? 1016 : m_br;
        if (m_bit >= 8 && m_bit < 8 + len)
            for (int n = 0; n < NSEG; n++) s[n] = latch_r[m_slot*NSEG + n];
        return s;
    endfunction

    task automatic chk(input string tag, input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic rand_inputs();
        logic [127:0] w;
        if ($urandom % 600 == 0) begin
            case ($urandom % 4)
                0: bright_r = 10'd0;
                1: bright_r = 10'd1016 + 10'($urandom % 8);
                default: bright_r = 10'($urandom % 1024);
            endcase
        end
        if ($urandom % 900 == 0) begin
            w = {$urandom, $urandom, $urandom, $urandom};
            latch_r = w[110:0];
        end
        if ($urandom % 7000 == 0) sel_r = ~sel_r;
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk("R3/R4/R5/R10 grid", longint'(grid_en), longint'(exp_grid()));
            chk("R6/R7/R8/R9 seg", longint'(seg_en), longint'(exp_seg()));
            if (meas) begin
                if (seg_en[0]) cnt_seg0++;
                if (seg_en != '0) cnt_anyseg++;
                if (grid_en == 3'b011) cnt_pair++;
                if (grid_en[2]) cnt_g3++;
            end
            if (rnd) rand_inputs();
        end
    endtask

    task automatic clear_counts();
        cnt_seg0 = 0; cnt_pair = 0; cnt_g3 = 0; cnt_anyseg = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 grid in reset", longint'(grid_en), 0);
        chk("R1 seg in reset", longint'(seg_en), 0);
        latch_r  = '1;
        bright_r = 10'd1023;
        sel_r    = 1'b1;
        rst_n    = 1'b1;

        // R2: grid rises after exactly 5 bit times of 4 clocks
        step(19);
        chk("R2 grid before bit 5", longint'(grid_en), 0);
        step(1);
        chk("R2 grid at bit 5", longint'(grid_en), 1);
        step(CYC - 20);

        // R7, R4: clamped brightness, pair sequence, one full cycle
        clear_counts(); meas = 1; step(CYC); meas = 0;
        chk("R7 seg0 clocks at clamp", cnt_seg0, 3 * 1016 * 4);
        chk("R4 grid pair clocks", cnt_pair, 1019 * 4);
        chk("R4 grid3 never used", cnt_g3, 0);

        // R8, R3: zero brightness, three-grid sequence
        sel_r = 1'b0; bright_r = 10'd0;
        step(CYC);
        clear_counts(); meas = 1; step(CYC); meas = 0;
        chk("R8 no segments at zero", cnt_anyseg, 0);
        chk("R3 grid3 clocks", cnt_g3, 1019 * 4);
        chk("R3 no pair", cnt_pair, 0);

        // R9, R10: deferred adoption
        bright_r = 10'd1016; sel_r = 1'b1;
        step(CYC);
        step(1600);
        bright_r = 10'd0;
        step(800);
        chk("R9 seg held after mid-slot change", longint'(seg_en[0]), 1);
        step(1736);
        chk("R9 seg off in next slot", longint'(seg_en), 0);
        chk("R3 second slot grid", longint'(grid_en), 2);
        sel_r = 1'b0;
        step(4496);
        chk("R10 third slot keeps pair", longint'(grid_en), 3);
        step(4056);
        chk("R3 first slot grid", longint'(grid_en), 1);
        step(8192);
        chk("R10 new order in next cycle", longint'(grid_en), 4);

        // random mix, checked every clock against the model (R6, R7, R9, R10)
        rnd = 1;
        step(5 * CYC);
        rnd = 0;

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule